// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control core of a successive-approximation converter. It switches the converter between two phases: an acquire phase, in which the input is tracked and the analog core sits in a low-power state, and a convert phase, in which the bit decisions are made. A parameterised cycle timer stands in for the bit-decision sequence. At the end of every conversion a stand-in result register is loaded with the running count of completed conversions. The result can be read while chip-select and read are both held low.

A conversion is requested by a falling edge on an active-low start input. The input passes through a synchronizer before the edge is detected. Once a conversion is running it always finishes: further start edges are ignored, and so is power-down. If the start input is still low when the conversion ends, the block times a minimum acquire period by itself and then begins the next conversion. This gives a self-paced, free-running stream. Free running is only possible after a genuine high-to-low transition has been seen since reset.

Top module: `adc_conv_seq`

## Requirements
- R1: During and after synchronous reset, with no start yet, `busy` is 0, `acq_low_pwr` is 1, and a read returns 0.
- R2: A falling edge on `cnv_start_n`, applied between clock edges, makes `busy` high from the third rising clock edge after it (SYNC_STAGES+1 edges, with SYNC_STAGES=2).
- R3: Each conversion holds `busy` high for exactly CONV_CYC consecutive clock cycles.
- R4: A falling edge on `cnv_start_n` while `busy` is high neither restarts, extends nor aborts that conversion. It is not queued: if the input has returned high, no further conversion follows.
- R5: Activity on `cs_n` and `rd_n` has no effect on when conversions start or end.
- R6: If `cnv_start_n` is still low when `busy` falls, `busy` stays low for exactly ACQ_CYC cycles and then rises again. This repeats with a period of CONV_CYC+ACQ_CYC cycles for as long as the input stays low.
- R7: After reset, a start input that is already low and stays low starts nothing. A high-to-low transition seen after reset is required before the first conversion.
- R8: Raising `pwr_down` during a conversion does not shorten it. While `pwr_down` is high in the acquire phase, no conversion starts. A start edge seen during power-down is discarded, not held for later.
- R9: `acq_low_pwr` is 1 exactly when `busy` is 0.
- R10: The result register increases by one (modulo 2^RES_W) at the end of every conversion and is cleared by reset. `rd_data` equals the result when `cs_n` and `rd_n` are both 0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnv_start_n | input | 1 | Conversion request, active low, asynchronous |
| pwr_down | input | 1 | Blocks new conversions while high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| busy | output | 1 | High during the convert phase |
| acq_low_pwr | output | 1 | High during the acquire phase (analog core in low power) |
| rd_data | output | RES_W | Stand-in result, gated by cs_n and rd_n |

## Verification
The bench sweeps the position of a second start pulse across every cycle of a conversion. A design that restarted, stretched or queued a conversion would show a longer or extra `busy` window. It holds the start input low through reset and again across a reset taken during free running. A design that treats a low level, rather than a transition, as the first request would begin converting at once. Power-down is raised mid-conversion and a start is then pulsed while it is high; a design that aborts, or that latches the pulse, would show a short window or a late conversion. The free-running run compares every `busy` cycle against the arithmetic period, so an off-by-one in the self-timed acquire count is seen directly.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic {
      PH_ACQ  = 1'b0,
      PH_CONV = 1'b1
   } phase_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adcseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   generate
      if (W < 1) begin : g_bad_width
         $error("adcseq_timer: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
   import adcseq_pkg::*;
#(
   parameter int unsigned CONV_CYC = 18,
   parameter int unsigned ACQ_CYC  = 4,
   parameter int unsigned RES_W    = 18,
   parameter int unsigned TW       = 5,
   parameter bit          AUTO_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_s_n,
   input  logic             pwr_down,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [TW-1:0]    tmr_val,
   output phase_e           phase,
   output logic [RES_W-1:0] res
);

   localparam logic [TW-1:0] CONV_LD = TW'(CONV_CYC - 1);
   localparam logic [TW-1:0] ACQ_LD  = TW'(ACQ_CYC - 1);

   phase_e           phase_q;
   logic             prev_q;
   logic             armed_q;
   logic [RES_W-1:0] res_q;
   logic             edge_fall;
   logic             auto_go;
   logic             go;
   logic             conv_end;

   assign edge_fall = prev_q & ~start_s_n;

   generate
      if (AUTO_EN) begin : g_auto
         assign auto_go = armed_q & ~start_s_n & tmr_zero;
      end else begin : g_noauto
         assign auto_go = 1'b0;
      end
   endgenerate

   assign go       = (phase_q == PH_ACQ) && !pwr_down && (edge_fall || auto_go);
   assign conv_end = (phase_q == PH_CONV) && tmr_zero;
   assign tmr_load = go || conv_end;
   assign tmr_val  = go ? CONV_LD : ACQ_LD;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_ACQ;
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
         res_q   <= '0;
      end else begin
         prev_q <= start_s_n;
         if (go) begin
            phase_q <= PH_CONV;
            armed_q <= 1'b1;
         end else if (conv_end) begin
            phase_q <= PH_ACQ;
            res_q   <= res_q + 1'b1;
         end
      end
   end

   assign phase = phase_q;
   assign res   = res_q;

   // R4: a running conversion is never cut short
   p_no_abort_r4: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_CONV && !tmr_zero) |=> (phase_q == PH_CONV));

   // R3: conversion ends as soon as the timer expires
   p_busy_end_r3: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_CONV && tmr_zero) |=> (phase_q == PH_ACQ));

   // R8: power-down holds the acquire phase
   p_pd_block_r8: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_ACQ && pwr_down) |=> (phase_q == PH_ACQ));

   // R7: no start before a first falling edge
   p_first_start_r7: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_ACQ && !armed_q && !edge_fall) |=> (phase_q == PH_ACQ));

   // R10: result steps by one at every conversion end
   p_res_step_r10: assert property (@(posedge clk) disable iff (rst)
      ($past(phase_q) == PH_CONV && phase_q == PH_ACQ)
         |-> (res_q == RES_W'($past(res_q) + 1'b1)));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adcseq_pkg::*;
#(
   parameter int unsigned CONV_CYC    = 18,
   parameter int unsigned ACQ_CYC     = 4,
   parameter int unsigned RES_W       = 18,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          AUTO_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnv_start_n,
   input  logic             pwr_down,
   input  logic             cs_n,
   input  logic             rd_n,
   output logic             busy,
   output logic             acq_low_pwr,
   output logic [RES_W-1:0] rd_data
);

   localparam int unsigned MAX_CYC = max_u(CONV_CYC, ACQ_CYC);
   localparam int unsigned TW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (CONV_CYC < 1) begin : g_bad_conv
         $error("adc_conv_seq: CONV_CYC must be at least 1");
      end
      if (ACQ_CYC < 1) begin : g_bad_acq
         $error("adc_conv_seq: ACQ_CYC must be at least 1");
      end
      if (RES_W < 1) begin : g_bad_res
         $error("adc_conv_seq: RES_W must be at least 1");
      end
   endgenerate

   logic             start_s_n;
   logic             tmr_zero;
   logic             tmr_load;
   logic [TW-1:0]    tmr_val;
   phase_e           phase;
   logic [RES_W-1:0] res;

   adcseq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (cnv_start_n),
      .q   (start_s_n)
   );

   adcseq_timer #(
      .W (TW)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   adcseq_ctrl #(
      .CONV_CYC (CONV_CYC),
      .ACQ_CYC  (ACQ_CYC),
      .RES_W    (RES_W),
      .TW       (TW),
      .AUTO_EN  (AUTO_EN)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .start_s_n (start_s_n),
      .pwr_down  (pwr_down),
      .tmr_zero  (tmr_zero),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .phase     (phase),
      .res       (res)
   );

   assign busy        = (phase == PH_CONV);
   assign acq_low_pwr = (phase == PH_ACQ);
   assign rd_data     = (!cs_n && !rd_n) ? res : '0;

endmodule

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;

   localparam int CONV = 6;
   localparam int ACQ  = 3;
   localparam int RW   = 8;
   localparam int PER  = CONV + ACQ;
   localparam int LAT  = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cnv_start_n = 1'b1;
   logic          pwr_down = 1'b0;
   logic          cs_n = 1'b1;
   logic          rd_n = 1'b1;
   logic          busy;
   logic          acq_low_pwr;
   logic [RW-1:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_res  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   adc_conv_seq #(
      .CONV_CYC    (CONV),
      .ACQ_CYC     (ACQ),
      .RES_W       (RW),
      .SYNC_STAGES (2),
      .AUTO_EN     (1'b1)
   ) dut (
      .clk         (clk),
      .rst         (rst),
      .cnv_start_n (cnv_start_n),
      .pwr_down    (pwr_down),
      .cs_n        (cs_n),
      .rd_n        (rd_n),
      .busy        (busy),
      .acq_low_pwr (acq_low_pwr),
      .rd_data     (rd_data)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic read_res(output int v);
      cs_n = 1'b0;
      rd_n = 1'b0;
      #1;
      v = int'(rd_data);
      cs_n = 1'b1;
      rd_n = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // watch busy stays 0 (and low-power 1) for n cycles; returns cycles that violated
   task automatic watch_quiet(input int n, output int bad);
      bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (busy !== 1'b0 || acq_low_pwr !== 1'b1) bad++;
      end
   endtask

   // drive a start at this negedge and compare busy per cycle to the arithmetic window
   task automatic run_seq(input bit free, input int p2, input bit tog, input bit pd4,
                          input int ncyc, input string tag);
      int  mism = 0;
      int  first_k = -1;
      int  first_act = 0;
      int  first_exp = 0;
      bit  lp_bad = 1'b0;
      cnv_start_n = 1'b0;
      for (int k = 1; k <= ncyc; k++) begin
         @(negedge clk);
         begin
            bit e;
            if (free) e = (k >= LAT) && (((k - LAT) % PER) < CONV);
            else      e = (k >= LAT) && (k < LAT + CONV);
            if (busy !== e) begin
               mism++;
               if (first_k < 0) begin
                  first_k = k; first_act = int'(busy); first_exp = int'(e);
               end
            end
            if (acq_low_pwr !== ~busy) lp_bad = 1'b1;
         end
         if (!free && k == 1) cnv_start_n = 1'b1;
         if (k == p2)         cnv_start_n = 1'b0;
         if (k == p2 + 1)     cnv_start_n = 1'b1;
         if (tog) begin
            cs_n = $urandom_range(0, 1);
            rd_n = $urandom_range(0, 1);
         end
         if (pd4 && k == 4) pwr_down = 1'b1;
      end
      cs_n = 1'b1;
      rd_n = 1'b1;
      cnv_start_n = 1'b1;
      check(mism == 0, {tag, " busy window"}, first_act, first_exp);
      if (mism != 0) $display("  first mismatch at cycle %0d of %s", first_k, tag);
      check(!lp_bad, "R9 low-power is inverse of busy", int'(lp_bad), 0);
   endtask

   initial begin
      int v;
      int bad;
      // R7: start input held low through reset and beyond
      cnv_start_n = 1'b0;
      idle(4);
      check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
      check(acq_low_pwr === 1'b1, "R1 low-power in reset", int'(acq_low_pwr), 1);
      read_res(v);
      check(v == 0, "R1 result in reset", v, 0);
      rst = 1'b0;
      watch_quiet(30, bad);
      check(bad == 0, "R7 no start while held low after power-up", bad, 0);
      cnv_start_n = 1'b1;
      idle(5);

      // R2 R3: single shots, then check result increments (R10)
      for (int s = 0; s < 3; s++) begin
         run_seq(1'b0, -1, 1'b0, 1'b0, LAT + CONV + ACQ + 4, "R2 R3 single shot");
         exp_res++;
         read_res(v);
         check(v == exp_res, "R10 result after single shot", v, exp_res);
      end
      cs_n = 1'b0;
      #1;
      check(rd_data == '0, "R10 no output with only cs_n low", int'(rd_data), 0);
      cs_n = 1'b1;
      rd_n = 1'b0;
      #1;
      check(rd_data == '0, "R10 no output with only rd_n low", int'(rd_data), 0);
      rd_n = 1'b1;
      idle(1);

      // R4: second start pulse at every cycle position inside the conversion
      for (int j = 2; j <= CONV; j++) begin
         run_seq(1'b0, j, 1'b0, 1'b0, LAT + CONV + ACQ + 6, "R4 retrigger ignored");
         exp_res++;
         idle(2);
      end
      read_res(v);
      check(v == exp_res, "R4 one result per sweep step", v, exp_res);

      // R5: chip-select and read chatter during a conversion
      for (int s = 0; s < 4; s++) begin
         run_seq(1'b0, -1, 1'b1, 1'b0, LAT + CONV + ACQ + 4, "R5 cs/rd activity");
         exp_res++;
      end
      read_res(v);
      check(v == exp_res, "R5 result count with cs/rd activity", v, exp_res);

      // R8: power-down mid-conversion, then a pulse while powered down
      run_seq(1'b0, -1, 1'b0, 1'b1, LAT + CONV + ACQ + 4, "R8 conversion completes under power-down");
      exp_res++;
      check(pwr_down === 1'b1, "R8 power-down still raised", int'(pwr_down), 1);
      cnv_start_n = 1'b0;
      idle(1);
      cnv_start_n = 1'b1;
      watch_quiet(15, bad);
      check(bad == 0, "R8 start ignored while powered down", bad, 0);
      pwr_down = 1'b0;
      watch_quiet(12, bad);
      check(bad == 0, "R8 discarded start not replayed", bad, 0);
      read_res(v);
      check(v == exp_res, "R8 result count", v, exp_res);

      // R6: free running, five conversions expected
      run_seq(1'b1, -1, 1'b0, 1'b0, LAT + 4 * PER + 1, "R6 free-running period");
      exp_res += 5;
      idle(CONV + ACQ + 6);
      read_res(v);
      check(v == (exp_res % 256), "R6 conversions in free run", v, exp_res % 256);

      // R7: reset during free running with the input still low
      cnv_start_n = 1'b0;
      idle(2 * PER);
      rst = 1'b1;
      idle(3);
      rst = 1'b0;
      watch_quiet(30, bad);
      check(bad == 0, "R7 reset clears free-run arming", bad, 0);
      read_res(v);
      check(v == 0, "R1 result cleared by reset", v, 0);
      cnv_start_n = 1'b1;
      idle(4);
      exp_res = 0;
      run_seq(1'b0, -1, 1'b0, 1'b0, LAT + CONV + ACQ + 4, "R2 first start after reset");
      exp_res++;
      read_res(v);
      check(v == exp_res, "R10 result after restart", v, exp_res);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(5 * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule